// File: doc/BRIEF.md
# Slot-Packed Stack Processor Core

This core is a small integer-only processor built around two stacks. Every 20-bit memory word it fetches holds four 5-bit opcodes. The core executes them in turn, using a data stack, a return stack and one address register. A single word-addressed synchronous memory port serves instruction fetch, literals, loads and stores. Read data arrives on the cycle after the address is driven.

The operations are arithmetic and logic on the top one or two data cells, moves between the two stacks, and loads and stores through the address register. Two post-incrementing transfers turn a block copy into a tight loop: a fetch that steps the address register, and a store that steps the return-stack top. A jump or call uses the bits below its own slot as a target field and discards the rest of the word.

Top module: `stack_core`

## Requirements
- R1: Reset is synchronous and high-active. It clears the program counter, the address register, both stack pointers, both top registers and every stack cell to zero. While reset is held the core drives address 0 with write enable low.
- R2: Fetch and slot order:
  - A word is fetched from the program counter, which then increments.
  - Slot 0 is bits 19:15, slot 1 is bits 14:10, slot 2 is bits 9:5 and slot 3 is bits 4:0. Slots run in order from 0 to 3.
  - After slot 3, the next word is fetched.
  - Opcode 0, and every opcode from 22 to 31, only advances to the next slot.
- R3: Arithmetic and logic opcodes:
  - 5 replaces the top and second cells with their sum.
  - 6 replaces them with their AND, and 7 with their XOR.
  - 8 inverts the top cell.
  - 9 shifts the top cell left by one.
  - 10 shifts the top cell right by one, keeping its sign bit.
- R4: Data-stack opcodes:
  - 11 duplicates the top cell.
  - 12 drops the top cell.
  - 13 pushes a copy of the second cell.
  - 4 pushes the memory word at the program counter, then increments the program counter.
- R5: Each stack is a top register over 8 further cells. Their pointer wraps, so deeper pushes silently overwrite the oldest cell, and over-popping returns wrapped cells.
- R6: Opcode 14 pops the data-stack top and pushes it onto the return stack. Opcode 15 pops the return-stack top and pushes it onto the data stack.
- R7: Address-register opcodes:
  - 16 pushes the memory word at the address register.
  - 17 writes the data-stack top to the address held in the address register, then pops the data stack.
  - 20 pops the data-stack top into the address register.
  - 21 pushes the address register's value.
- R8: Post-increment opcodes:
  - 18 pushes the memory word at the address register, then adds one to the address register.
  - 19 writes the data-stack top to the address held in the return-stack top, pops the data stack, then adds one to the return-stack top.
- R9: Jump, call and return:
  - 1 jumps and 2 calls.
  - The target keeps the program counter's upper bits and replaces its low 15−5·slot bits with the bits of the word below that slot. The rest of the word is abandoned.
  - A call first pushes the current program counter onto the return stack.
  - 3 pops the return-stack top into the program counter.
- R10: The write enable rises only while opcode 17 or 19 executes, and the write data is always the data-stack top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 20 | Word address for fetch, literal, load or store |
| mem_wdata | output | 20 | Store data |
| mem_we | output | 1 | Store enable |
| mem_rdata | input | 20 | Read data, valid the cycle after its address |

## Verification
The stack wrap and the interaction of calls, literals and jumps inside one word are hard to reach from the memory port, because their effects stay hidden until a later store exposes a stack cell. The stimulus therefore runs whole programs. Directed programs overfill the data stack and then store every cell, run a copy loop, and do a call that returns mid-program. Random programs, weighted towards stores, mix every opcode and jump slot. Each observed store is compared in order with a bench instruction model.

// File: rtl/stack_core.sv
module stack_core #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  output logic [19:0] mem_addr,
  output logic [19:0] mem_wdata,
  output logic        mem_we,
  input  logic [19:0] mem_rdata
);
  localparam int W  = 20;
  localparam int PW = $clog2(DEPTH);

  localparam logic [4:0] OP_NOP = 5'd0,  OP_JMP = 5'd1,  OP_CALL = 5'd2,  OP_RET = 5'd3;
  localparam logic [4:0] OP_LIT = 5'd4,  OP_ADD = 5'd5,  OP_AND = 5'd6,   OP_XOR = 5'd7;
  localparam logic [4:0] OP_NOT = 5'd8,  OP_SHL = 5'd9,  OP_SHR = 5'd10,  OP_DUP = 5'd11;
  localparam logic [4:0] OP_DROP = 5'd12, OP_OVER = 5'd13, OP_TOR = 5'd14, OP_FROMR = 5'd15;
  localparam logic [4:0] OP_LD = 5'd16, OP_ST = 5'd17, OP_LDP = 5'd18, OP_STP = 5'd19;
  localparam logic [4:0] OP_TOA = 5'd20, OP_FROMA = 5'd21;

  typedef enum logic [1:0] {S_FETCH, S_LOAD, S_EXEC, S_READ} state_t;

  state_t         state;
  logic [1:0]     slot;
  logic [W-1:0]   ir, pc, a, t, r;
  logic [W-1:0]   dstk [DEPTH];
  logic [W-1:0]   rstk [DEPTH];
  logic [PW-1:0]  dsp, rsp;
  logic [4:0]     op;
  logic [W-1:0]   s, rs, lowm, tgt, d_new, r_new;
  logic           d_push, d_pop, r_push, r_pop, exec, adv;

  assign op        = ir[15 - 5*slot +: 5];
  assign s         = dstk[dsp];
  assign rs        = rstk[rsp];
  assign lowm      = (W'(1) << (15 - 5*slot)) - W'(1);
  assign tgt       = (pc & ~lowm) | (ir & lowm);
  assign exec      = (state == S_EXEC);
  assign mem_wdata = t;
  assign adv       = (state == S_READ) ||
                     (exec && !(op inside {OP_LIT, OP_LD, OP_LDP, OP_JMP, OP_CALL, OP_RET}));

  always_comb begin
    d_push = 1'b0; d_pop = 1'b0; d_new = t;
    r_push = 1'b0; r_pop = 1'b0; r_new = r;
    mem_addr = pc; mem_we = 1'b0;
    if (state == S_READ) begin
      d_push = 1'b1; d_new = mem_rdata;
    end else if (exec) begin
      case (op)
        OP_ADD:   begin d_pop = 1'b1; d_new = s + t; end
        OP_AND:   begin d_pop = 1'b1; d_new = s & t; end
        OP_XOR:   begin d_pop = 1'b1; d_new = s ^ t; end
        OP_NOT:   d_new = ~t;
        OP_SHL:   d_new = {t[W-2:0], 1'b0};
        OP_SHR:   d_new = {t[W-1], t[W-1:1]};
        OP_DUP:   d_push = 1'b1;
        OP_DROP:  begin d_pop = 1'b1; d_new = s; end
        OP_OVER:  begin d_push = 1'b1; d_new = s; end
        OP_TOR:   begin d_pop = 1'b1; d_new = s; r_push = 1'b1; r_new = t; end
        OP_FROMR: begin d_push = 1'b1; d_new = r; r_pop = 1'b1; r_new = rs; end
        OP_LD, OP_LDP: mem_addr = a;
        OP_ST:    begin mem_addr = a; mem_we = 1'b1; d_pop = 1'b1; d_new = s; end
        OP_STP:   begin mem_addr = r; mem_we = 1'b1; d_pop = 1'b1; d_new = s; r_new = r + W'(1); end
        OP_TOA:   begin d_pop = 1'b1; d_new = s; end
        OP_FROMA: begin d_push = 1'b1; d_new = a; end
        OP_CALL:  begin r_push = 1'b1; r_new = pc; end
        OP_RET:   begin r_pop = 1'b1; r_new = rs; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH; slot <= '0; ir <= '0; pc <= '0; a <= '0;
      t <= '0; r <= '0; dsp <= '0; rsp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dstk[i] <= '0;
        rstk[i] <= '0;
      end
    end else begin
      t <= d_new;
      r <= r_new;
      if (d_push) begin
        dstk[dsp + PW'(1)] <= t;
        dsp <= dsp + PW'(1);
      end else if (d_pop) dsp <= dsp - PW'(1);
      if (r_push) begin
        rstk[rsp + PW'(1)] <= r;
        rsp <= rsp + PW'(1);
      end else if (r_pop) rsp <= rsp - PW'(1);

      case (state)
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          ir <= mem_rdata; pc <= pc + W'(1); slot <= '0; state <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_LIT:  begin pc <= pc + W'(1); state <= S_READ; end
            OP_LD:   state <= S_READ;
            OP_LDP:  begin a <= a + W'(1); state <= S_READ; end
            OP_TOA:  a <= t;
            OP_JMP, OP_CALL: begin pc <= tgt; state <= S_FETCH; end
            OP_RET:  begin pc <= r; state <= S_FETCH; end
            default: ;
          endcase
        end
        default: ;
      endcase

      if (adv) begin
        if (slot == 2'd3) state <= S_FETCH;
        else begin
          slot <= slot + 2'd1;
          state <= S_EXEC;
        end
      end
    end
  end
endmodule

module stack_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  state,
  input logic [1:0]  slot,
  input logic [4:0]  op,
  input logic [19:0] pc,
  input logic [19:0] a,
  input logic [19:0] r,
  input logic [19:0] mem_addr,
  input logic        mem_we
);
  localparam logic [1:0] C_FETCH = 2'd0, C_LOAD = 2'd1, C_EXEC = 2'd2, C_READ = 2'd3;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == 20'd0 && a == 20'd0 && state == C_FETCH && !mem_we));

  // R2
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == C_LOAD) |=> (pc == $past(pc) + 20'd1 && slot == 2'd0 && state == C_EXEC));

  // R2
  nop_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (state == C_EXEC && op == 5'd0 && slot != 2'd3) |=> (state == C_EXEC && slot == $past(slot) + 2'd1));

  // R8
  ldp_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == C_EXEC && op == 5'd18) |=> (a == $past(a) + 20'd1 && state == C_READ));

  // R8
  stp_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == C_EXEC && op == 5'd19) |-> (mem_we && mem_addr == r));

  // R8
  stp_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == C_EXEC && op == 5'd19) |=> (r == $past(r) + 20'd1));

  // R9
  ret_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == C_EXEC && op == 5'd3) |=> (pc == $past(r) && state == C_FETCH));

  // R10
  we_exec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == C_EXEC && (op == 5'd17 || op == 5'd19)));
endmodule

bind stack_core stack_core_chk u_chk (.*);

// File: tb/stack_core_bench.sv
module stack_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic        load_img = 1'b0;
  logic [19:0] mem [256];
  logic [19:0] img [256];

  int vectors = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stack_core u_stack_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (load_img) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
    end else begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  // reference instruction model
  logic [19:0] rm_mem [256];
  logic [19:0] rm_ds [8];
  logic [19:0] rm_rs [8];
  logic [19:0] rm_pc, rm_a, rm_t, rm_r;
  logic [2:0]  rm_dsp, rm_rsp;
  logic [19:0] exp_addr [64];
  logic [19:0] exp_data [64];
  int          n_exp;

  function automatic logic [19:0] wd(int o0, int o1, int o2, int o3);
    return {o0[4:0], o1[4:0], o2[4:0], o3[4:0]};
  endfunction

  task automatic dpush(logic [19:0] x);
    rm_dsp = rm_dsp + 3'd1; rm_ds[rm_dsp] = rm_t; rm_t = x;
  endtask
  task automatic dpop();
    rm_t = rm_ds[rm_dsp]; rm_dsp = rm_dsp - 3'd1;
  endtask
  task automatic rpush(logic [19:0] x);
    rm_rsp = rm_rsp + 3'd1; rm_rs[rm_rsp] = rm_r; rm_r = x;
  endtask
  task automatic rpop();
    rm_r = rm_rs[rm_rsp]; rm_rsp = rm_rsp - 3'd1;
  endtask
  task automatic rstore(logic [19:0] ad, logic [19:0] dt);
    if (n_exp < 64) begin
      exp_addr[n_exp] = ad; exp_data[n_exp] = dt; n_exp++;
    end
    rm_mem[ad[7:0]] = dt;
  endtask

  task automatic ref_run();
    logic [19:0] w, lowm, sv;
    logic [4:0]  o;
    bit          brk;
    rm_pc = 0; rm_a = 0; rm_t = 0; rm_r = 0; rm_dsp = 0; rm_rsp = 0; n_exp = 0;
    for (int i = 0; i < 8; i++) begin rm_ds[i] = 0; rm_rs[i] = 0; end
    for (int i = 0; i < 256; i++) rm_mem[i] = img[i];
    for (int words = 0; words < 400 && n_exp < 64; words++) begin
      w = rm_mem[rm_pc[7:0]]; rm_pc = rm_pc + 1; brk = 0;
      for (int k = 0; k < 4 && !brk; k++) begin
        o = w[15 - 5*k +: 5];
        lowm = (20'd1 << (15 - 5*k)) - 20'd1;
        case (o)
          1:  begin rm_pc = (rm_pc & ~lowm) | (w & lowm); brk = 1; end
          2:  begin rpush(rm_pc); rm_pc = (rm_pc & ~lowm) | (w & lowm); brk = 1; end
          3:  begin sv = rm_r; rpop(); rm_pc = sv; brk = 1; end
          4:  begin dpush(rm_mem[rm_pc[7:0]]); rm_pc = rm_pc + 1; end
          5:  begin rm_t = rm_ds[rm_dsp] + rm_t; rm_dsp = rm_dsp - 3'd1; end
          6:  begin rm_t = rm_ds[rm_dsp] & rm_t; rm_dsp = rm_dsp - 3'd1; end
          7:  begin rm_t = rm_ds[rm_dsp] ^ rm_t; rm_dsp = rm_dsp - 3'd1; end
          8:  rm_t = ~rm_t;
          9:  rm_t = rm_t << 1;
          10: rm_t = {rm_t[19], rm_t[19:1]};
          11: dpush(rm_t);
          12: dpop();
          13: dpush(rm_ds[rm_dsp]);
          14: begin rpush(rm_t); dpop(); end
          15: begin dpush(rm_r); rpop(); end
          16: dpush(rm_mem[rm_a[7:0]]);
          17: begin rstore(rm_a, rm_t); dpop(); end
          18: begin dpush(rm_mem[rm_a[7:0]]); rm_a = rm_a + 1; end
          19: begin rstore(rm_r, rm_t); dpop(); rm_r = rm_r + 1; end
          20: begin rm_a = rm_t; dpop(); end
          21: dpush(rm_a);
          default: ;
        endcase
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [19:0] act, logic [19:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic run_prog(string tag);
    int n, cyc;
    @(negedge clk); rst = 1'b1; load_img = 1'b1;
    @(negedge clk); load_img = 1'b0;
    ref_run();
    @(negedge clk);
    // R1: reset state visible at the port
    check(mem_addr == 20'd0 && !mem_we, "R1", "reset address/we", {mem_addr[18:0], mem_we}, 20'd0);
    rst = 1'b0;
    n = 0; cyc = 0;
    while (n < n_exp && cyc < 4500) begin
      @(negedge clk); cyc++;
      if (mem_we) begin
        check(mem_addr == exp_addr[n], tag, "store address", mem_addr, exp_addr[n]);
        check(mem_wdata == exp_data[n], tag, "store data", mem_wdata, exp_data[n]);
        n++;
      end
    end
    check(n == n_exp, tag, "store count", 20'(n), 20'(n_exp));
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 20'd0;
  endtask

  initial begin
    int p;
    logic [4:0] o;
    void'($urandom(32'h5eed));

    // R8: block copy with post-increment fetch and store
    clear_img();
    img[0] = wd(4, 20, 4, 14); img[1] = 20'd100; img[2] = 20'd200;
    img[3] = wd(18, 19, 18, 19); img[4] = wd(18, 19, 18, 19);
    img[5] = {5'd1, 15'd5};
    for (int i = 0; i < 4; i++) img[100 + i] = 20'h0a000 + 20'(i * 7);
    run_prog("R8 copy");

    // R9: call into a subroutine with a literal before it, then return
    clear_img();
    img[0] = {5'd4, 5'd2, 10'd10}; img[1] = 20'd7;
    img[10] = wd(11, 5, 3, 0);
    img[2] = wd(4, 20, 17, 0); img[3] = 20'd50;
    img[4] = {5'd1, 15'd4};
    run_prog("R9 call");

    // R5: twelve pushes overfill the 8-cell stack, then every cell is stored
    clear_img();
    p = 0;
    for (int g = 0; g < 3; g++) begin
      img[p] = wd(4, 4, 4, 4); p++;
      for (int j = 0; j < 4; j++) begin img[p] = 20'd11 + 20'(g * 4 + j); p++; end
    end
    img[p] = wd(4, 20, 17, 17); p++; img[p] = 20'd60; p++;
    img[p] = wd(17, 17, 17, 17); p++;
    img[p] = wd(17, 17, 17, 17); p++;
    img[p] = wd(17, 17, 17, 17); p++;
    img[p] = {5'd1, 15'(p)};
    run_prog("R5 wrap");

    // R3 R4 R6 R7: arithmetic, stack shuffles and address moves
    clear_img();
    img[0] = wd(4, 4, 13, 13); img[1] = 20'h12345; img[2] = 20'hf0f0f;
    img[3] = wd(5, 11, 14, 8);
    img[4] = wd(15, 7, 9, 10);
    img[5] = wd(6, 12, 21, 11);
    img[6] = wd(4, 20, 17, 17); img[7] = 20'd70;
    img[8] = wd(16, 17, 21, 17);
    img[9] = wd(17, 17, 17, 25);
    img[10] = {5'd1, 15'd10};
    run_prog("R3 R4 R6 R7");

    // R2 R3 R4 R6 R7 R9 R10: random programs
    for (int prog = 0; prog < 20; prog++) begin
      for (int i = 0; i < 256; i++) begin
        if ($urandom % 4 == 0) img[i] = 20'($urandom);
        else begin
          for (int k = 0; k < 4; k++) begin
            o = 5'($urandom % 32);
            if ($urandom % 4 == 0) o = ($urandom % 2) ? 5'd17 : 5'd19;
            img[i][15 - 5*k +: 5] = o;
          end
        end
      end
      run_prog("R2 R3 R4 R6 R7 R9 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule